// File: doc/BRIEF.md
# Indexed Configuration Register Bank

This block holds the configuration state of a larger unit as a set of byte-wide registers, reached through a simple synchronous bus. A window of 32 direct addresses decodes general scratch registers, an index register, a data port and a test register. A further 32 configuration registers have no address of their own. Software first loads the index register with a register number. It then reads or writes the data port, which acts on the configuration register the index selects.

The contents of all indirect configuration registers are driven out in parallel as one flat vector. The fields of configuration register 0 are also decoded into their own outputs: a trailing-bit time count, a leading-bit time count and a delimiter byte count. The test register drives out a test command whose meaning belongs to other logic. Reads are registered. Read data appears on `rd_data` one clock after the read strobe and stays there until the next read.

Top module: `cfg_regbank`

## Requirements
- R1: While `rst` is high and after it falls, every register reads 00h, `cfg_flat` is all zero and `test_cmd` and the field outputs are zero.
- R2: Direct addresses 0 to GP_COUNT-1 (default 0..15) are read/write scratch registers. Read data appears on `rd_data` one clock after `rd_en` and is held unchanged while `rd_en` stays low.
- R3: Direct address 24 is the index register. Only its low 5 bits are stored. A read returns them with bits 7:5 always 0.
- R4: A write to direct address 25 (the data port) stores `wr_data` in the configuration register selected by the current index. The index is left unchanged.
- R5: A read from the data port returns the configuration register selected by the index, with the same one-cycle latency as any other read. The index is left unchanged.
- R6: Direct address 31 is the test register. Bits 6:0 are stored and driven on `test_cmd`. Bit 7 is reserved: writes to it are discarded and it reads 0.
- R7: Direct addresses 16 to 23 and 26 to 30 hold no register. They read 00h, and writes to them change no register.
- R8: `dribble_cnt`, `header_cnt` and `sdlim_cnt` equal bits 7:5, 4:2 and 1:0 of configuration register 0.
- R9: `cfg_flat` bits [8k+7:8k] carry configuration register k. They change only in the clock that follows a data-port write.
- R10: When `rd_en` and `wr_en` are both high for the same address, the read returns the value from before that write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 5 | Direct register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| cfg_flat | output | 256 | All indirect configuration registers, register k at bits [8k+7:8k] |
| test_cmd | output | 7 | Test command bits from the test register |
| dribble_cnt | output | 3 | Trailing-bit count field of configuration register 0 |
| header_cnt | output | 3 | Leading-bit count field of configuration register 0 |
| sdlim_cnt | output | 2 | Delimiter byte count field of configuration register 0 |

## Verification
Several properties are checked by the assertions on every cycle:
- reserved and unused index bits always read zero;
- unmapped addresses always read zero;
- read data holds between reads;
- the configuration vector moves only after a data-port write;
- the decoded fields always match configuration register 0.

Other behaviours need the bench's directed scenarios, which keep a model of the register contents:
- that a data-port access lands on the register the index selects;
- that writes to holes leave every real register intact;
- that a simultaneous read and write returns the old value.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;

   typedef enum logic [2:0] {
      SEL_NONE  = 3'd0,
      SEL_GP    = 3'd1,
      SEL_INDEX = 3'd2,
      SEL_PORT  = 3'd3,
      SEL_TEST  = 3'd4
   } sel_e;

   // Keep only the bits that are not reserved.
   function automatic logic [7:0] strip_rsv(input logic [7:0] value, input logic [7:0] rsv_mask);
      return value & ~rsv_mask;
   endfunction

endpackage

// File: rtl/cfg_regbank_decode.sv
module cfg_regbank_decode
   import cfg_regbank_pkg::*;
#(
   parameter int DIR_AW     = 5,
   parameter int GP_COUNT   = 16,
   parameter int INDEX_ADDR = 24,
   parameter int PORT_ADDR  = 25,
   parameter int TEST_ADDR  = 31
) (
   input  logic [DIR_AW-1:0] addr,
   output sel_e              sel
);

   always_comb begin
      if (int'(addr) < GP_COUNT)
         sel = SEL_GP;
      else if (int'(addr) == INDEX_ADDR)
         sel = SEL_INDEX;
      else if (int'(addr) == PORT_ADDR)
         sel = SEL_PORT;
      else if (int'(addr) == TEST_ADDR)
         sel = SEL_TEST;
      else
         sel = SEL_NONE;
   end

endmodule

// File: rtl/cfg_regbank_direct.sv
module cfg_regbank_direct
   import cfg_regbank_pkg::*;
#(
   parameter int         DW            = 8,
   parameter int         DIR_AW        = 5,
   parameter int         IND_AW        = 5,
   parameter int         GP_COUNT      = 16,
   parameter logic [7:0] TEST_RSV_MASK = 8'h80,
   localparam int        GP_AW         = (GP_COUNT > 1) ? $clog2(GP_COUNT) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  sel_e              sel,
   input  logic [DIR_AW-1:0] addr,
   input  logic              wr_en,
   input  logic [DW-1:0]     wr_data,
   output logic [DW-1:0]     gp_q [GP_COUNT],
   output logic [IND_AW-1:0] index_q,
   output logic [DW-1:0]     test_q
);

   logic [GP_AW-1:0] gp_sel;
   assign gp_sel = addr[GP_AW-1:0];

   for (genvar g = 0; g < GP_COUNT; g++) begin : g_gp
      logic hit;
      assign hit = wr_en && (sel == SEL_GP) && (int'(gp_sel) == g);
      always_ff @(posedge clk) begin
         if (rst)
            gp_q[g] <= '0;
         else if (hit)
            gp_q[g] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         index_q <= '0;
      else if (wr_en && sel == SEL_INDEX)
         index_q <= wr_data[IND_AW-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst)
         test_q <= '0;
      else if (wr_en && sel == SEL_TEST)
         test_q <= strip_rsv(wr_data, TEST_RSV_MASK);
   end

endmodule

// File: rtl/cfg_regbank_indirect.sv
module cfg_regbank_indirect #(
   parameter int  DW     = 8,
   parameter int  IND_AW = 5,
   localparam int N_IND  = 1 << IND_AW
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              port_wr,
   input  logic [IND_AW-1:0] index,
   input  logic [DW-1:0]     wr_data,
   output logic [DW-1:0]     ind_q [N_IND]
);

   for (genvar k = 0; k < N_IND; k++) begin : g_cfg
      logic hit;
      assign hit = port_wr && (int'(index) == k);
      always_ff @(posedge clk) begin
         if (rst)
            ind_q[k] <= '0;
         else if (hit)
            ind_q[k] <= wr_data;
      end
   end

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
   import cfg_regbank_pkg::*;
#(
   parameter int         DW            = 8,
   parameter int         DIR_AW        = 5,
   parameter int         IND_AW        = 5,
   parameter int         GP_COUNT      = 16,
   parameter int         INDEX_ADDR    = 24,
   parameter int         PORT_ADDR     = 25,
   parameter int         TEST_ADDR     = 31,
   parameter logic [7:0] TEST_RSV_MASK = 8'h80,
   localparam int        N_IND         = 1 << IND_AW,
   localparam int        N_DIR         = 1 << DIR_AW,
   localparam int        GP_AW         = (GP_COUNT > 1) ? $clog2(GP_COUNT) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [DIR_AW-1:0]   addr,
   input  logic                wr_en,
   input  logic [DW-1:0]       wr_data,
   input  logic                rd_en,
   output logic [DW-1:0]       rd_data,
   output logic [N_IND*DW-1:0] cfg_flat,
   output logic [DW-2:0]       test_cmd,
   output logic [2:0]          dribble_cnt,
   output logic [2:0]          header_cnt,
   output logic [1:0]          sdlim_cnt
);

   // Elaboration-time parameter checks
   if (DW != 8) begin : g_bad_dw
      $error("cfg_regbank: DW must be 8");
   end
   if (IND_AW >= DW) begin : g_bad_iaw
      $error("cfg_regbank: IND_AW must be narrower than DW");
   end
   if (GP_COUNT < 1 || (1 << GP_AW) != GP_COUNT) begin : g_bad_gp
      $error("cfg_regbank: GP_COUNT must be a power of two");
   end
   if (INDEX_ADDR < GP_COUNT || PORT_ADDR < GP_COUNT || TEST_ADDR < GP_COUNT) begin : g_bad_ovl
      $error("cfg_regbank: special registers overlap scratch window");
   end
   if (INDEX_ADDR == PORT_ADDR || INDEX_ADDR == TEST_ADDR || PORT_ADDR == TEST_ADDR) begin : g_bad_dup
      $error("cfg_regbank: special registers must be distinct");
   end
   if (INDEX_ADDR >= N_DIR || PORT_ADDR >= N_DIR || TEST_ADDR >= N_DIR) begin : g_bad_rng
      $error("cfg_regbank: special address out of window");
   end

   sel_e              sel;
   logic [DW-1:0]     gp_q  [GP_COUNT];
   logic [DW-1:0]     ind_q [N_IND];
   logic [IND_AW-1:0] index_q;
   logic [DW-1:0]     test_q;
   logic [DW-1:0]     rd_next;

   cfg_regbank_decode #(
      .DIR_AW(DIR_AW), .GP_COUNT(GP_COUNT), .INDEX_ADDR(INDEX_ADDR),
      .PORT_ADDR(PORT_ADDR), .TEST_ADDR(TEST_ADDR)
   ) u_decode (
      .addr(addr),
      .sel (sel)
   );

   cfg_regbank_direct #(
      .DW(DW), .DIR_AW(DIR_AW), .IND_AW(IND_AW), .GP_COUNT(GP_COUNT),
      .TEST_RSV_MASK(TEST_RSV_MASK)
   ) u_direct (
      .clk    (clk),
      .rst    (rst),
      .sel    (sel),
      .addr   (addr),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .gp_q   (gp_q),
      .index_q(index_q),
      .test_q (test_q)
   );

   cfg_regbank_indirect #(
      .DW(DW), .IND_AW(IND_AW)
   ) u_indirect (
      .clk    (clk),
      .rst    (rst),
      .port_wr(wr_en && sel == SEL_PORT),
      .index  (index_q),
      .wr_data(wr_data),
      .ind_q  (ind_q)
   );

   // Read selection; the stored index picks the data-port source
   always_comb begin
      unique case (sel)
         SEL_GP:    rd_next = gp_q[addr[GP_AW-1:0]];
         SEL_INDEX: rd_next = {{(DW-IND_AW){1'b0}}, index_q};
         SEL_PORT:  rd_next = ind_q[index_q];
         SEL_TEST:  rd_next = test_q;
         default:   rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         rd_data <= '0;
      else if (rd_en)
         rd_data <= rd_next;
   end

   for (genvar k = 0; k < N_IND; k++) begin : g_flat
      assign cfg_flat[k*DW +: DW] = ind_q[k];
   end

   assign test_cmd    = test_q[DW-2:0];
   assign dribble_cnt = ind_q[0][7:5];
   assign header_cnt  = ind_q[0][4:2];
   assign sdlim_cnt   = ind_q[0][1:0];

endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
   parameter int         DW            = 8,
   parameter int         DIR_AW        = 5,
   parameter int         IND_AW        = 5,
   parameter int         GP_COUNT      = 16,
   parameter int         INDEX_ADDR    = 24,
   parameter int         PORT_ADDR     = 25,
   parameter int         TEST_ADDR     = 31,
   parameter logic [7:0] TEST_RSV_MASK = 8'h80,
   localparam int        N_IND         = 1 << IND_AW
) (
   input logic                clk,
   input logic                rst,
   input logic [DIR_AW-1:0]   addr,
   input logic                wr_en,
   input logic                rd_en,
   input logic [DW-1:0]       rd_data,
   input logic [N_IND*DW-1:0] cfg_flat,
   input logic [DW-2:0]       test_cmd,
   input logic [2:0]          dribble_cnt,
   input logic [2:0]          header_cnt,
   input logic [1:0]          sdlim_cnt
);

   logic hole;
   assign hole = (int'(addr) >= GP_COUNT) && (int'(addr) != INDEX_ADDR) &&
                 (int'(addr) != PORT_ADDR) && (int'(addr) != TEST_ADDR);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (rd_data == '0 && cfg_flat == '0 && test_cmd == '0));

   // R2
   rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rd_data));

   // R3
   index_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && int'(addr) == INDEX_ADDR) |=> (rd_data[DW-1:IND_AW] == '0));

   // R6
   test_rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && int'(addr) == TEST_ADDR) |=> ((rd_data & TEST_RSV_MASK) == '0));

   // R7
   hole_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && hole) |=> (rd_data == '0));

   // R9
   cfg_only_by_port_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && int'(addr) == PORT_ADDR) |=> $stable(cfg_flat));

   // R6
   test_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && int'(addr) == TEST_ADDR) |=> $stable(test_cmd));

   // R8
   fields_match_chk: assert property (@(posedge clk) disable iff (rst)
      {dribble_cnt, header_cnt, sdlim_cnt} == cfg_flat[7:0]);

endmodule

bind cfg_regbank cfg_regbank_chk #(
   .DW(DW), .DIR_AW(DIR_AW), .IND_AW(IND_AW), .GP_COUNT(GP_COUNT),
   .INDEX_ADDR(INDEX_ADDR), .PORT_ADDR(PORT_ADDR), .TEST_ADDR(TEST_ADDR),
   .TEST_RSV_MASK(TEST_RSV_MASK)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .addr       (addr),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .rd_data    (rd_data),
   .cfg_flat   (cfg_flat),
   .test_cmd   (test_cmd),
   .dribble_cnt(dribble_cnt),
   .header_cnt (header_cnt),
   .sdlim_cnt  (sdlim_cnt)
);

// File: tb/cfg_regbank_bench.sv
module cfg_regbank_bench;

   logic         clk = 1'b0;
   logic         rst;
   logic [4:0]   addr;
   logic         wr_en;
   logic [7:0]   wr_data;
   logic         rd_en;
   logic [7:0]   rd_data;
   logic [255:0] cfg_flat;
   logic [6:0]   test_cmd;
   logic [2:0]   dribble_cnt;
   logic [2:0]   header_cnt;
   logic [1:0]   sdlim_cnt;

   int checks = 0;
   int errors = 0;
   logic [7:0] cfg_model [32];
   logic [7:0] gp_model  [16];

   always #10 clk = ~clk;

   cfg_regbank u_cfg_regbank (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .cfg_flat(cfg_flat), .test_cmd(test_cmd),
      .dribble_cnt(dribble_cnt), .header_cnt(header_cnt), .sdlim_cnt(sdlim_cnt)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic check_cfg(input string req);
      for (int k = 0; k < 32; k++)
         check(req, cfg_flat[k*8 +: 8], cfg_model[k]);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 rd_data", rd_data, 0);
      check("R1 test_cmd", test_cmd, 0);
      check("R1 fields", {dribble_cnt, header_cnt, sdlim_cnt}, 0);
      check_cfg("R1 cfg_flat");
      for (int a = 0; a < 32; a++) begin
         rd(a[4:0], d);
         check("R1 direct read", d, 0);
      end
   endtask

   task automatic t_scratch();
      logic [7:0] d;
      for (int a = 0; a < 16; a++) begin
         gp_model[a] = 8'(a * 17 + 3);
         wr(a[4:0], gp_model[a]);
      end
      for (int a = 0; a < 16; a++) begin
         rd(a[4:0], d);
         check("R2 scratch readback", d, gp_model[a]);
      end
      rd(5'd7, d);
      repeat (3) @(negedge clk);
      check("R2 read data held", rd_data, gp_model[7]);
   endtask

   task automatic t_index();
      logic [7:0] d;
      wr(5'd24, 8'hFF);
      rd(5'd24, d);
      check("R3 index upper bits", d, 8'h1F);
      wr(5'd24, 8'hE5);
      rd(5'd24, d);
      check("R3 index low bits", d, 8'h05);
   endtask

   task automatic t_port();
      logic [7:0] d;
      for (int k = 0; k < 32; k++) begin
         cfg_model[k] = 8'((k * 37 + 11) ^ 8'h5A);
         wr(5'd24, 8'(k));
         wr(5'd25, cfg_model[k]);
         rd(5'd24, d);
         check("R4 index kept after port write", d, k);
      end
      check_cfg("R9 cfg_flat layout");
      for (int k = 31; k >= 0; k--) begin
         wr(5'd24, 8'(k) | 8'hE0);
         rd(5'd25, d);
         check("R5 port read", d, cfg_model[k]);
         rd(5'd24, d);
         check("R5 index kept after port read", d, k);
      end
   endtask

   task automatic t_test();
      logic [7:0] d;
      wr(5'd31, 8'hFF);
      rd(5'd31, d);
      check("R6 test read masks bit7", d, 8'h7F);
      check("R6 test_cmd", test_cmd, 7'h7F);
      wr(5'd31, 8'h80);
      rd(5'd31, d);
      check("R6 reserved bit write discarded", d, 8'h00);
      wr(5'd31, 8'h2C);
      check("R6 test_cmd value", test_cmd, 7'h2C);
   endtask

   task automatic t_holes();
      logic [7:0] d;
      wr(5'd24, 8'd9);
      for (int a = 16; a < 31; a++)
         if (a != 24 && a != 25) wr(a[4:0], 8'hAA);
      for (int a = 16; a < 31; a++)
         if (a != 24 && a != 25) begin
            rd(a[4:0], d);
            check("R7 hole reads zero", d, 0);
         end
      for (int a = 0; a < 16; a++) begin
         rd(a[4:0], d);
         check("R7 scratch untouched", d, gp_model[a]);
      end
      rd(5'd24, d);
      check("R7 index untouched", d, 9);
      rd(5'd31, d);
      check("R7 test untouched", d, 8'h2C);
      check_cfg("R7 cfg untouched");
   endtask

   task automatic t_fields();
      wr(5'd24, 8'd0);
      wr(5'd25, 8'hAE);
      cfg_model[0] = 8'hAE;
      check("R8 dribble", dribble_cnt, 3'd5);
      check("R8 header", header_cnt, 3'd3);
      check("R8 sdlim", sdlim_cnt, 2'd2);
      wr(5'd25, 8'h1D);
      cfg_model[0] = 8'h1D;
      check("R8 fields second", {dribble_cnt, header_cnt, sdlim_cnt}, 8'h1D);
      check("R9 cfg reg0", cfg_flat[7:0], 8'h1D);
   endtask

   task automatic t_same_cycle();
      logic [7:0] d;
      wr(5'd24, 8'd3);
      @(negedge clk);
      addr = 5'd25; wr_data = 8'h99; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check("R10 read returns old", rd_data, cfg_model[3]);
      cfg_model[3] = 8'h99;
      rd(5'd25, d);
      check("R10 write took effect", d, 8'h99);
      @(negedge clk);
      addr = 5'd4; wr_data = 8'h66; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check("R10 scratch read returns old", rd_data, gp_model[4]);
      gp_model[4] = 8'h66;
      rd(5'd4, d);
      check("R10 scratch write took effect", d, 8'h66);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
      for (int k = 0; k < 32; k++) cfg_model[k] = '0;
      for (int a = 0; a < 16; a++) gp_model[a] = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_scratch();
      t_index();
      t_port();
      t_test();
      t_holes();
      t_fields();
      t_same_cycle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule